// File: doc/BRIEF.md
# Selectable CRC-8 / XOR Checksum Unit

This unit produces the integrity byte for one serial transaction. A framing block upstream hands it bytes one per valid strobe: the command byte first, then one to four data bytes. A start strobe opens a frame and an end strobe closes it. One clock after the end strobe, the unit presents the 8-bit checksum along with a one-cycle valid pulse.

Two algorithms are available: a CRC-8 with generator x^8 + x^2 + x + 1, and a plain bytewise XOR. The algorithm depends on the direction of the transfer. Writes always use the CRC. For reads, a 2-bit configuration field chooses between no checksum, XOR or CRC.

In continuous-read traffic no command byte travels on the wire. For those frames the unit seeds its accumulator as if command byte 0x44 had been sent first. As a result, a frame of all-zero data still yields a nonzero checksum.

Top module: `cks_unit`

## Requirements
- R1: The CRC starts from 0x00, uses the generator 0x07 (x^8 + x^2 + x + 1), takes each byte MSB first and has no final inversion. The bytes "123456789" (0x31..0x39) give 0xF4.
- R2: When `is_write_i` is 1 at the start strobe, the frame uses the CRC for any value of `cfg_i`, and `sum_en_o` is 1 with the result.
- R3: For a read frame (`is_write_i` = 0), `cfg_i` = 2'b00 gives `sum_o` = 0x00 with `sum_en_o` = 0. `cfg_i` = 2'b01 gives the bytewise XOR of all frame bytes. `cfg_i` = 2'b10 or 2'b11 gives the CRC.
- R4: The checksum covers every byte strobed between the start and end strobes, in arrival order, including a command byte followed by up to four data bytes.
- R5: When `cont_rd_i` is 1 at the start strobe of a read frame, the accumulator is seeded as though 0x44 had been processed before the first strobed byte. For a write frame, `cont_rd_i` has no effect.
- R6: A continuous-read frame whose data bytes are all 0x00 gives a nonzero `sum_o` in XOR mode (0x44) and in CRC mode.
- R7: A start strobe discards any previous accumulator contents. A byte strobed in the same cycle as the start strobe is the first byte of the new frame, and a frame may start in the cycle right after the previous end strobe.
- R8: A byte strobed together with the end strobe is included. `sum_vld_o` is 1 in exactly the cycle after each end strobe. `sum_o` and `sum_en_o` hold their values until the next end strobe.
- R9: After reset, `sum_o` = 0x00, `sum_vld_o` = 0 and `sum_en_o` = 0.
- R10: Direction, configuration and continuous-read selection are captured at the start strobe. Changes to them later in the frame do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame strobe, clears and seeds the accumulator |
| vld_i | input | 1 | Byte strobe, `data_i` is part of the frame |
| data_i | input | 8 | Frame byte |
| eof_i | input | 1 | End-of-frame strobe |
| is_write_i | input | 1 | 1 for a write transaction, 0 for a read |
| cfg_i | input | 2 | Read checksum selection: 00 off, 01 XOR, 1x CRC |
| cont_rd_i | input | 1 | Frame is continuous-read data with an implied command byte |
| sum_o | output | 8 | Checksum of the last closed frame |
| sum_vld_o | output | 1 | One-cycle pulse, the cycle after the end strobe |
| sum_en_o | output | 1 | The last closed frame carries a checksum |

## Verification
A wrong accumulator value or wrong latched mode stays hidden until the end strobe of its frame. One clock later it appears as a wrong `sum_o` or `sum_en_o`, so each frame is scored against an independently computed checksum at its valid pulse. Seed errors show only on continuous-read frames, and show most plainly with all-zero data. Mode-latch errors show only when the inputs change mid-frame. Stale state across frames shows only on back-to-back frames, so each of these cases gets its own frame.

// File: rtl/cks_pkg.sv
package cks_pkg;
   // Checksum algorithm chosen for one frame.
   typedef enum logic [1:0] {
      CK_OFF = 2'b00,
      CK_XOR = 2'b01,
      CK_CRC = 2'b10
   } ck_mode_e;
endpackage

// File: rtl/cks_mode_dec.sv
module cks_mode_dec
   import cks_pkg::*;
(
   input  logic       is_write_i,
   input  logic [1:0] cfg_i,
   output ck_mode_e   mode_o
);
   // Writes force the polynomial; reads follow the configuration field.
   always_comb begin
      if (is_write_i)    mode_o = CK_CRC;
      else if (cfg_i[1]) mode_o = CK_CRC;
      else if (cfg_i[0]) mode_o = CK_XOR;
      else               mode_o = CK_OFF;
   end
endmodule

// File: rtl/cks_crc_step.sv
module cks_crc_step #(
   parameter int          W    = 8,
   parameter logic [W-1:0] POLY = 8'h07
) (
   input  logic [W-1:0] state_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] state_o
);
   // One full byte of an MSB-first CRC, unrolled one stage per bit.
   logic [W-1:0] st [0:W];

   assign st[0] = state_i ^ data_i;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign st[k+1] = st[k][W-1] ? ((st[k] << 1) ^ POLY) : (st[k] << 1);
   end

   assign state_o = st[W];
endmodule

// File: rtl/cks_unit.sv
module cks_unit
   import cks_pkg::*;
#(
   parameter int           W           = 8,
   parameter logic [W-1:0] POLY        = 8'h07,
   parameter logic [W-1:0] INIT        = '0,
   parameter logic [W-1:0] IMPLIED_CMD = 8'h44
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sof_i,
   input  logic         vld_i,
   input  logic [W-1:0] data_i,
   input  logic         eof_i,
   input  logic         is_write_i,
   input  logic [1:0]   cfg_i,
   input  logic         cont_rd_i,
   output logic [W-1:0] sum_o,
   output logic         sum_vld_o,
   output logic         sum_en_o
);
   // Elaboration-time parameter checks.
   if (W < 4) begin : g_bad_width
      $error("cks_unit: W must be at least 4");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("cks_unit: generator must have a constant term");
   end

   ck_mode_e     mode_now, mode_q, mode_use;
   logic [W-1:0] acc_q, acc_nx, base, seed;
   logic [W-1:0] seed_crc, crc_nx;
   logic         use_cont;

   cks_mode_dec u_dec (
      .is_write_i (is_write_i),
      .cfg_i      (cfg_i),
      .mode_o     (mode_now)
   );

   // Accumulator value after the implied command byte (constant inputs).
   cks_crc_step #(.W(W), .POLY(POLY)) u_seed_step (
      .state_i (INIT),
      .data_i  (IMPLIED_CMD),
      .state_o (seed_crc)
   );

   cks_crc_step #(.W(W), .POLY(POLY)) u_data_step (
      .state_i (base),
      .data_i  (data_i),
      .state_o (crc_nx)
   );

   assign use_cont = cont_rd_i & ~is_write_i;
   assign mode_use = sof_i ? mode_now : mode_q;

   always_comb begin
      unique case (mode_now)
         CK_CRC:  seed = use_cont ? seed_crc : INIT;
         CK_XOR:  seed = use_cont ? IMPLIED_CMD : '0;
         default: seed = '0;
      endcase
   end

   assign base = sof_i ? seed : acc_q;

   always_comb begin
      acc_nx = base;
      if (vld_i) begin
         unique case (mode_use)
            CK_CRC:  acc_nx = crc_nx;
            CK_XOR:  acc_nx = base ^ data_i;
            default: acc_nx = base;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         mode_q    <= CK_OFF;
         sum_o     <= '0;
         sum_vld_o <= 1'b0;
         sum_en_o  <= 1'b0;
      end else begin
         acc_q     <= acc_nx;
         sum_vld_o <= eof_i;
         if (sof_i) mode_q <= mode_now;
         if (eof_i) begin
            sum_o    <= (mode_use == CK_OFF) ? '0 : acc_nx;
            sum_en_o <= (mode_use != CK_OFF);
         end
      end
   end
endmodule

// File: rtl/cks_chk.sv
module cks_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sof_i,
   input logic         vld_i,
   input logic [W-1:0] data_i,
   input logic         eof_i,
   input logic         is_write_i,
   input logic         cont_rd_i,
   input logic [W-1:0] sum_o,
   input logic         sum_vld_o,
   input logic         sum_en_o
);
   // Checker-side frame tracking.
   logic wr_lat, cr_lat, zero_lat;
   logic wr_cur, cr_cur, zero_cur;

   assign wr_cur   = sof_i ? is_write_i : wr_lat;
   assign cr_cur   = sof_i ? (cont_rd_i & ~is_write_i) : cr_lat;
   assign zero_cur = (sof_i ? 1'b1 : zero_lat) & (~vld_i | (data_i == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_lat   <= 1'b0;
         cr_lat   <= 1'b0;
         zero_lat <= 1'b1;
      end else begin
         wr_lat   <= wr_cur;
         cr_lat   <= cr_cur;
         zero_lat <= zero_cur;
      end
   end

   assert_vld_after_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eof_i |=> sum_vld_o);

   assert_no_stray_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_i |=> !sum_vld_o);

   assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_i |=> ($stable(sum_o) && $stable(sum_en_o)));

   assert_off_is_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_vld_o && !sum_en_o) |-> (sum_o == '0));

   assert_write_has_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && wr_cur) |=> sum_en_o);

   assert_cont_zero_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && cr_cur && zero_cur) |=> (!sum_en_o || (sum_o != '0)));
endmodule

bind cks_unit cks_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sof_i      (sof_i),
   .vld_i      (vld_i),
   .data_i     (data_i),
   .eof_i      (eof_i),
   .is_write_i (is_write_i),
   .cont_rd_i  (cont_rd_i),
   .sum_o      (sum_o),
   .sum_vld_o  (sum_vld_o),
   .sum_en_o   (sum_en_o)
);

// File: tb/tb_cks_unit.sv
`timescale 1ns/1ps
module tb_cks_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof_i = 1'b0, vld_i = 1'b0, eof_i = 1'b0;
   logic [7:0] data_i = '0;
   logic       is_write_i = 1'b0, cont_rd_i = 1'b0;
   logic [1:0] cfg_i = 2'b00;
   logic [7:0] sum_o;
   logic       sum_vld_o, sum_en_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [7:0] exp_v [$];
   logic       exp_e [$];
   string      exp_t [$];
   logic [7:0] last_v;

   always #2 clk = ~clk;

   cks_unit dut (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .vld_i(vld_i), .data_i(data_i),
      .eof_i(eof_i), .is_write_i(is_write_i), .cfg_i(cfg_i), .cont_rd_i(cont_rd_i),
      .sum_o(sum_o), .sum_vld_o(sum_vld_o), .sum_en_o(sum_en_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Bitwise reference CRC-8, generator 0x07, MSB first.
   function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c;
      for (int j = 7; j >= 0; j--) begin
         if (r[7] ^ b[j]) r = {r[6:0], 1'b0} ^ 8'h07;
         else             r = {r[6:0], 1'b0};
      end
      return r;
   endfunction

   // Drive one frame; expected value pushed to the scoreboard first.
   task automatic frame(input string tag, input logic wr, input logic [1:0] cfg,
                        input logic cont, input logic [7:0] fb [16], input int n,
                        input bit chg, input bit b2b);
      logic [7:0] acc;
      logic       en;
      logic       is_xor;
      en     = wr | (cfg != 2'b00);
      is_xor = !wr && cfg == 2'b01;
      acc    = 8'h00;
      if (cont && !wr) acc = is_xor ? 8'h44 : crc_byte(8'h00, 8'h44);
      for (int i = 0; i < n; i++) acc = is_xor ? (acc ^ fb[i]) : crc_byte(acc, fb[i]);
      if (!en) acc = 8'h00;
      exp_v.push_back(acc);
      exp_e.push_back(en);
      exp_t.push_back(tag);
      last_v = acc;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) begin
            is_write_i = wr; cfg_i = cfg; cont_rd_i = cont;
         end
         if (chg && i == 1) begin
            is_write_i = ~wr; cfg_i = cfg ^ 2'b11; cont_rd_i = ~cont;
         end
         sof_i  = (i == 0);
         vld_i  = 1'b1;
         data_i = fb[i];
         eof_i  = (i == n - 1);
      end
      if (!b2b) begin
         @(negedge clk);
         sof_i = 1'b0; vld_i = 1'b0; eof_i = 1'b0; data_i = 8'h00;
      end
   endtask

   // Monitor: pop and compare at each result pulse.
   always @(negedge clk) begin
      if (rst_n && sum_vld_o) begin
         if (exp_v.size() == 0) begin
            check("R8 unexpected result pulse", 32'd1, 32'd0);
         end else begin
            check({exp_t[0], " sum"}, {24'd0, sum_o}, {24'd0, exp_v[0]});
            check({exp_t[0], " en"}, {31'd0, sum_en_o}, {31'd0, exp_e[0]});
            void'(exp_v.pop_front());
            void'(exp_e.pop_front());
            void'(exp_t.pop_front());
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] fb [16];
      for (int i = 0; i < 16; i++) fb[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 sum", {24'd0, sum_o}, 32'h0);
      check("R9 vld", {31'd0, sum_vld_o}, 32'h0);
      check("R9 en", {31'd0, sum_en_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 standard check string, fixed expectation 0xF4
      for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
      frame("R1 check string", 1'b1, 2'b00, 1'b0, fb, 9, 1'b0, 1'b0);
      @(negedge clk);
      check("R1 literal 0xF4", {24'd0, last_v}, 32'hF4);

      fb[0] = 8'h65; fb[1] = 8'h43; fb[2] = 8'h21;
      frame("R2 write ignores XOR cfg", 1'b1, 2'b01, 1'b0, fb, 3, 1'b0, 1'b0);
      frame("R3 read XOR", 1'b0, 2'b01, 1'b0, fb, 3, 1'b0, 1'b0);
      // R8 held after the pulse
      repeat (3) @(negedge clk);
      check("R8 held sum", {24'd0, sum_o}, 32'h07);
      check("R8 pulse gone", {31'd0, sum_vld_o}, 32'h0);
      frame("R3 read off", 1'b0, 2'b00, 1'b0, fb, 3, 1'b0, 1'b0);
      frame("R3 read cfg 11 CRC", 1'b0, 2'b11, 1'b0, fb, 3, 1'b0, 1'b0);

      fb[0] = 8'h44; fb[1] = 8'hDE; fb[2] = 8'hAD; fb[3] = 8'hBE; fb[4] = 8'hEF;
      frame("R4 cmd plus 32-bit data", 1'b0, 2'b10, 1'b0, fb, 5, 1'b0, 1'b0);

      fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56;
      frame("R5 cont read CRC seed", 1'b0, 2'b10, 1'b1, fb, 3, 1'b0, 1'b0);
      frame("R5 write ignores cont", 1'b1, 2'b00, 1'b1, fb, 3, 1'b0, 1'b0);

      fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h00;
      frame("R6 cont read CRC zeros", 1'b0, 2'b10, 1'b1, fb, 3, 1'b0, 1'b0);
      @(negedge clk);
      check("R6 CRC zeros nonzero", {31'd0, last_v != 8'h00}, 32'h1);
      frame("R6 cont read XOR zeros", 1'b0, 2'b01, 1'b1, fb, 3, 1'b0, 1'b0);
      @(negedge clk);
      check("R6 XOR zeros is 0x44", {24'd0, last_v}, 32'h44);

      fb[0] = 8'hA5; fb[1] = 8'h5A; fb[2] = 8'hC3; fb[3] = 8'h3C;
      frame("R10 mid-frame changes", 1'b0, 2'b01, 1'b0, fb, 4, 1'b1, 1'b0);

      // R7 back-to-back frames, second starts right after first end strobe
      fb[0] = 8'hFF; fb[1] = 8'h81;
      frame("R7 first of pair", 1'b0, 2'b10, 1'b0, fb, 2, 1'b0, 1'b1);
      fb[0] = 8'h3E;
      frame("R7 single-byte second", 1'b1, 2'b00, 1'b0, fb, 1, 1'b0, 1'b0);

      repeat (4) @(negedge clk);
      check("R8 all results delivered", exp_v.size(), 32'd0);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule